// File: doc/BRIEF.md
# Open-Drain I2C Bit Engine

This block carries out the bit-level work of an I2C master on two open-drain wires: it creates start and stop conditions, shifts a byte out and samples the slave's acknowledge, and shifts a byte in and answers with a master acknowledge. Neither wire is ever driven high. The block only turns a low-side driver on or off, and the external pull-up supplies every logic 1. A controller above it issues one operation at a time on a small command port. It waits for a single-cycle done pulse and then picks up the received byte or the acknowledge seen from the slave.

Every release of the clock wire is followed by a wait until the wire is actually sensed high through a two-flop synchronizer, so a slave can hold the clock low for as long as it needs. The half-bit delay D is not a fixed constant. It is recomputed by a small serial divider whenever the system clock frequency input changes: D = max(floor(f / 2 400 000) − 7, 1). D is 44 from reset, and a frequency input of 0 leaves D unchanged. An operation uses the D that was in force at the cycle it was accepted.

Commands are encoded on `cmd_op` as 0 = start, 1 = stop, 2 = write byte, 3 = read byte.

Top module: `i2c_od_bit_engine`

## Requirements
- R1: While reset is held and right after it, both drive-low outputs are 0 (wires released), `busy` is 0 and `done` is 0.
- R2: D equals max(floor(f/2400000) − 7, 1) for a non-zero `sys_freq_hz` f. It is 44 after reset, and a value of 0 on `sys_freq_hz` keeps the last D.
- R3: A start (op 0) releases SDA, then SCL, waits for SCL high, waits D, pulls SDA low, waits D, then pulls SCL low. SDA therefore falls while SCL is high. `done` comes 2D+2 edges after the accepting edge when SCL was already high, and 2D+4 edges after it when SCL was low.
- R4: A stop (op 1) pulls SDA low, waits D, releases SCL and waits for it high, waits D, then releases SDA. SDA therefore rises while SCL is high. `done` comes 2D+3 edges after the accepting edge, plus any clock-stretch time.
- R5: A write (op 2) sends `cmd_byte` MSB first in 8 bit slots, then runs a 9th slot with SDA released. `ack_seen` becomes 1 when SDA was low at the 9th sample and 0 otherwise. SDA changes only while SCL is low. `done` comes 9·(2D+4) edges after the accepting edge.
- R6: A read (op 3) releases SDA for 8 slots and assembles the sampled bits MSB first into `rx_byte`. In the 9th slot it drives SDA low when `cmd_ack` is 1 and releases SDA when `cmd_ack` is 0. Its timing is the same as a write.
- R7: After each SCL release the engine stalls until the synchronized SCL reads high. The high phase then lasts D+3 cycles, so a slave that holds SCL low for S extra cycles lengthens the operation by exactly S cycles per release.
- R8: `cmd_valid` is ignored while `busy` is 1. An operation in progress keeps its bits, its timing and its single done pulse.
- R9: `done` is high for exactly one clock per accepted operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_freq_hz | input | 32 | System clock frequency in Hz, from which D is derived; 0 = keep |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_op | input | 2 | 0 start, 1 stop, 2 write byte, 3 read byte |
| cmd_byte | input | 8 | Byte to transmit for a write |
| cmd_ack | input | 1 | For a read: 1 = answer ACK (SDA low), 0 = NACK |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | 8 | Byte assembled by the last read |
| ack_seen | output | 1 | 1 when the slave held SDA low in the last write's 9th slot |
| sda_in | input | 1 | Sensed level of the SDA wire |
| scl_in | input | 1 | Sensed level of the SCL wire |
| sda_drive_low | output | 1 | 1 turns on the SDA low driver |
| scl_drive_low | output | 1 | 1 turns on the SCL low driver |

## Verification
The bench checks the delay formula at its clamp and rounding edges: just below and at an integer multiple of 2.4 MHz, quotients at or under 7, a large frequency, and a zero input that must keep the old count. A divider that rounds, skips the clamp or reloads on zero shows up as a wrong start-to-done time. All 256 bytes are swept in both directions with acknowledge values alternating, which exposes a reversed bit order, a sample taken on the wrong side of the clock edge, or an inverted acknowledge. A start issued with SCL low and one issued with SCL high must differ by exactly the synchronizer delay. A stretched clock must add exactly the stretch time, so an engine that ignores the wire finishes early. A command injected while busy must leave the byte, the timing and the done count untouched.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_S_REL,
    ST_S_WAIT,
    ST_S_D1,
    ST_S_D2,
    ST_P_D1,
    ST_P_WAIT,
    ST_P_D2,
    ST_B_NEXT,
    ST_B_D1,
    ST_B_WAIT,
    ST_B_D2
  } st_e;
endpackage

// File: rtl/i2cb_sync.sv
module i2cb_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_in,
  output logic [N-1:0] q_out
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk) begin
      if (rst) sh_q <= '1;
      else     sh_q <= {sh_q[STAGES-2:0], d_in[i]};
    end
    assign q_out[i] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/i2cb_delay_calc.sv
module i2cb_delay_calc #(
  parameter int FREQ_W      = 32,
  parameter int DLY_W       = 16,
  parameter int DIVISOR     = 2400000,
  parameter int OFFSET      = 7,
  parameter int DEFAULT_DLY = 44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FREQ_W-1:0] freq_in,
  output logic [DLY_W-1:0]  dly_out
);
  localparam int CNT_W = $clog2(FREQ_W + 1);
  localparam logic [FREQ_W:0]   DIV_V = (FREQ_W + 1)'(DIVISOR);
  localparam logic [FREQ_W-1:0] OFF_V = FREQ_W'(OFFSET);
  localparam logic [FREQ_W-1:0] MAX_V = FREQ_W'((64'd1 << DLY_W) - 64'd1);

  logic [FREQ_W-1:0] seen_q, quo_q, quo_nx;
  logic [FREQ_W:0]   rem_q, rem_sh, rem_nx;
  logic [CNT_W-1:0]  cnt_q;
  logic              run_q, ge;
  logic [DLY_W-1:0]  dly_q;

  function automatic logic [DLY_W-1:0] clamp(input logic [FREQ_W-1:0] q);
    logic [FREQ_W-1:0] diff;
    diff = q - OFF_V;
    if (q <= OFF_V)      return DLY_W'(1);
    else if (diff > MAX_V) return '1;
    else                 return diff[DLY_W-1:0];
  endfunction

  always_comb begin
    rem_sh = {rem_q[FREQ_W-1:0], quo_q[FREQ_W-1]};
    ge     = (rem_sh >= DIV_V);
    rem_nx = ge ? (rem_sh - DIV_V) : rem_sh;
    quo_nx = {quo_q[FREQ_W-2:0], ge};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      dly_q  <= DLY_W'(DEFAULT_DLY);
    end else if (freq_in != seen_q && freq_in != '0) begin
      seen_q <= freq_in;
      quo_q  <= freq_in;
      rem_q  <= '0;
      cnt_q  <= CNT_W'(FREQ_W);
      run_q  <= 1'b1;
    end else if (run_q) begin
      rem_q <= rem_nx;
      quo_q <= quo_nx;
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        run_q <= 1'b0;
        dly_q <= clamp(quo_nx);
      end
    end
  end

  assign dly_out = dly_q;

  assert_dly_floor_R2: assert property (@(posedge clk) disable iff (rst)
    dly_q != '0);
  assert_zero_keeps_R2: assert property (@(posedge clk) disable iff (rst)
    (freq_in == '0 && !run_q) |=> $stable(dly_q));
endmodule

// File: rtl/i2cb_seq.sv
module i2cb_seq
  import i2cb_pkg::*;
#(
  parameter int DLY_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_byte,
  input  logic              cmd_ack,
  input  logic [DLY_W-1:0]  dly_in,
  input  logic              sda_s,
  input  logic              scl_s,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              ack_seen,
  output logic              sda_low,
  output logic              scl_low
);
  localparam int SLOT_W = $clog2(DATA_W + 1);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(DATA_W);

  st_e               st;
  op_e               op_q;
  logic [DATA_W-1:0] shf_q, rx_q;
  logic              mack_q, ack_q, busy_q, done_q, sda_low_q, scl_low_q;
  logic [SLOT_W-1:0] slot_q;
  logic [DLY_W-1:0]  cnt_q, dly_q;
  logic              slot_bit, cnt_zero;

  always_comb begin
    if (slot_q == LAST) slot_bit = (op_q == OP_READ) ? !mack_q : 1'b1;
    else                slot_bit = (op_q == OP_WRITE) ? shf_q[DATA_W-1] : 1'b1;
  end
  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      op_q      <= OP_START;
      shf_q     <= '0;
      rx_q      <= '0;
      mack_q    <= 1'b0;
      ack_q     <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      sda_low_q <= 1'b0;
      scl_low_q <= 1'b0;
      slot_q    <= '0;
      cnt_q     <= '0;
      dly_q     <= DLY_W'(1);
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (cmd_valid) begin
          op_q   <= op_e'(cmd_op);
          shf_q  <= cmd_byte;
          mack_q <= cmd_ack;
          dly_q  <= dly_in;
          slot_q <= '0;
          busy_q <= 1'b1;
          case (op_e'(cmd_op))
            OP_START: begin sda_low_q <= 1'b0; st <= ST_S_REL; end
            OP_STOP:  begin
              sda_low_q <= 1'b1;
              cnt_q     <= dly_in - DLY_W'(1);
              st        <= ST_P_D1;
            end
            default:  st <= ST_B_NEXT;
          endcase
        end
        ST_S_REL: begin scl_low_q <= 1'b0; st <= ST_S_WAIT; end
        ST_S_WAIT: if (scl_s) begin cnt_q <= dly_q - DLY_W'(1); st <= ST_S_D1; end
        ST_S_D1: if (cnt_zero) begin
          sda_low_q <= 1'b1;
          cnt_q     <= dly_q - DLY_W'(1);
          st        <= ST_S_D2;
        end else cnt_q <= cnt_q - DLY_W'(1);
        ST_S_D2: if (cnt_zero) begin
          scl_low_q <= 1'b1;
          st        <= ST_IDLE;
          busy_q    <= 1'b0;
          done_q    <= 1'b1;
        end else cnt_q <= cnt_q - DLY_W'(1);
        ST_P_D1: if (cnt_zero) begin
          scl_low_q <= 1'b0;
          st        <= ST_P_WAIT;
        end else cnt_q <= cnt_q - DLY_W'(1);
        ST_P_WAIT: if (scl_s) begin cnt_q <= dly_q - DLY_W'(1); st <= ST_P_D2; end
        ST_P_D2: if (cnt_zero) begin
          sda_low_q <= 1'b0;
          st        <= ST_IDLE;
          busy_q    <= 1'b0;
          done_q    <= 1'b1;
        end else cnt_q <= cnt_q - DLY_W'(1);
        ST_B_NEXT: begin
          sda_low_q <= !slot_bit;
          cnt_q     <= dly_q - DLY_W'(1);
          st        <= ST_B_D1;
        end
        ST_B_D1: if (cnt_zero) begin
          scl_low_q <= 1'b0;
          st        <= ST_B_WAIT;
        end else cnt_q <= cnt_q - DLY_W'(1);
        ST_B_WAIT: if (scl_s) begin cnt_q <= dly_q - DLY_W'(1); st <= ST_B_D2; end
        ST_B_D2: if (cnt_zero) begin
          scl_low_q <= 1'b1;
          if (slot_q == LAST) begin
            if (op_q == OP_WRITE) ack_q <= !sda_s;
            if (op_q == OP_READ)  rx_q  <= shf_q;
            st     <= ST_IDLE;
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            shf_q  <= {shf_q[DATA_W-2:0], sda_s};
            slot_q <= slot_q + SLOT_W'(1);
            st     <= ST_B_NEXT;
          end
        end else cnt_q <= cnt_q - DLY_W'(1);
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign rx_byte  = rx_q;
  assign ack_seen = ack_q;
  assign sda_low  = sda_low_q;
  assign scl_low  = scl_low_q;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  assert_stretch_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_B_WAIT && !scl_s) |=> (st == ST_B_WAIT));
  assert_data_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_B_D2) |-> $stable(sda_low_q));
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cmd_valid) |=> ($stable(op_q) && $stable(dly_q)));
  assert_start_order_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_S_D2) |-> (sda_low_q && !scl_low_q));
  assert_stop_order_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_P_D2) |-> (sda_low_q && !scl_low_q));
endmodule

// File: rtl/i2c_od_bit_engine.sv
module i2c_od_bit_engine #(
  parameter int FREQ_W      = 32,
  parameter int DLY_W       = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIVISOR     = 2400000,
  parameter int OFFSET      = 7,
  parameter int DEFAULT_DLY = 44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FREQ_W-1:0] sys_freq_hz,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_byte,
  input  logic              cmd_ack,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              ack_seen,
  input  logic              sda_in,
  input  logic              scl_in,
  output logic              sda_drive_low,
  output logic              scl_drive_low
);
  logic [DLY_W-1:0] dly;
  logic [1:0]       lines_s;

  i2cb_delay_calc #(
    .FREQ_W(FREQ_W), .DLY_W(DLY_W), .DIVISOR(DIVISOR),
    .OFFSET(OFFSET), .DEFAULT_DLY(DEFAULT_DLY)
  ) u_dly (
    .clk(clk), .rst(rst), .freq_in(sys_freq_hz), .dly_out(dly)
  );

  i2cb_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_in({scl_in, sda_in}), .q_out(lines_s)
  );

  i2cb_seq #(.DLY_W(DLY_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_ack(cmd_ack),
    .dly_in(dly), .sda_s(lines_s[0]), .scl_s(lines_s[1]),
    .busy(busy), .done(done), .rx_byte(rx_byte), .ack_seen(ack_seen),
    .sda_low(sda_drive_low), .scl_low(scl_drive_low)
  );
endmodule

// File: tb/tb_i2c_od_bit_engine.sv
module tb_i2c_od_bit_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] sys_freq_hz = 32'd0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [7:0]  cmd_byte = 8'd0;
  logic        cmd_ack = 1'b0;
  logic        busy, done, ack_seen, sda_drive_low, scl_drive_low;
  logic [7:0]  rx_byte;
  logic        sda_line, scl_line, slave_low, stretch_en, stretch_low;
  int          str_cnt, stretch_len;
  int          total = 0, fails = 0, cyc = 0;
  int          start_cnt = 0, stop_cnt = 0, done_cnt = 0;
  logic [8:0]  resp, cap;
  int          idx;

  always #4 clk = ~clk;

  assign stretch_low = stretch_en && (str_cnt != 0);
  assign scl_line = !(scl_drive_low || stretch_low);
  assign sda_line = !(sda_drive_low || slave_low);

  i2c_od_bit_engine dut (
    .clk(clk), .rst(rst), .sys_freq_hz(sys_freq_hz),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_ack(cmd_ack),
    .busy(busy), .done(done), .rx_byte(rx_byte), .ack_seen(ack_seen),
    .sda_in(sda_line), .scl_in(scl_line),
    .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (scl_drive_low) str_cnt <= stretch_len;
    else if (str_cnt != 0) str_cnt <= str_cnt - 1;
  end

  always @(negedge clk) if (done) done_cnt++;
  always @(negedge sda_line) if (scl_line) start_cnt++;
  always @(posedge sda_line) if (scl_line) stop_cnt++;

  always @(posedge scl_line) if (idx < 9) cap[idx] = sda_line;
  always @(negedge scl_line) begin
    idx++;
    slave_low = (idx < 9) ? !resp[idx] : 1'b0;
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic slave_set(logic [8:0] r);
    resp = r;
    idx = 0;
    cap = '0;
    slave_low = !r[0];
  endtask

  task automatic run_cmd(logic [1:0] op, logic [7:0] b, logic a, bit inject, output int lat);
    int c0;
    @(negedge clk);
    cmd_op = op; cmd_byte = b; cmd_ack = a; cmd_valid = 1'b1; c0 = cyc;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (inject) begin
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'd3; cmd_byte = ~b;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    lat = cyc - c0;
    @(negedge clk);
    chk("R9 done width", int'(done), 0);
  endtask

  function automatic int exp_dly(longint f);
    longint q;
    q = f / 2400000;
    return (q > 7) ? int'(q - 7) : 1;
  endfunction

  task automatic do_start(int d, bit from_low, string tag);
    int lat, s0;
    s0 = start_cnt;
    slave_set(9'h1FF);
    run_cmd(2'd0, 8'h00, 1'b0, 1'b0, lat);
    chk({tag, " R3 start latency"}, lat, from_low ? 2*d + 5 : 2*d + 3);
    chk("R3 start condition", start_cnt - s0, 1);
  endtask

  task automatic do_stop(int d, int extra, string tag);
    int lat, p0;
    p0 = stop_cnt;
    slave_set(9'h1FF);
    run_cmd(2'd1, 8'h00, 1'b0, 1'b0, lat);
    chk({tag, " R4 stop latency"}, lat, 2*d + 4 + extra);
    chk("R4 stop condition", stop_cnt - p0, 1);
  endtask

  task automatic do_write(int d, logic [7:0] b, logic slv_ack, int extra, bit inject);
    int lat;
    logic [8:0] r;
    r = {slv_ack, 8'hFF};
    slave_set(r);
    run_cmd(2'd2, b, 1'b0, inject, lat);
    chk("R5 write latency", lat, 9*(2*d + 4) + 1 + extra);
    for (int k = 0; k < 8; k++) chk("R5 write bit order MSB first", int'(cap[k]), int'(b[7-k]));
    chk("R5 ack_seen", int'(ack_seen), int'(!slv_ack));
  endtask

  task automatic do_read(int d, logic [7:0] b, logic a);
    int lat;
    logic [8:0] r;
    for (int k = 0; k < 8; k++) r[k] = b[7-k];
    r[8] = 1'b1;
    slave_set(r);
    run_cmd(2'd3, 8'h00, a, 1'b0, lat);
    chk("R6 read latency", lat, 9*(2*d + 4) + 1);
    chk("R6 rx_byte", int'(rx_byte), int'(b));
    chk("R6 master ack level", int'(cap[8]), int'(!a));
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    fails++; total++;
    $display("FAIL R9 watchdog: done never arrived, actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
    $finish;
  end

  initial begin
    longint freqs [7] = '{21599999, 21600000, 24000000, 125000000, 19200000, 1000000, 300000000};
    int d, s0, p0, dc;
    stretch_en = 1'b0; stretch_len = 0; str_cnt = 0;
    slave_set(9'h1FF);
    repeat (3) @(negedge clk);
    chk("R1 sda released in reset", int'(sda_drive_low), 0);
    chk("R1 scl released in reset", int'(scl_drive_low), 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 sda released after reset", int'(sda_drive_low), 0);
    chk("R1 scl released after reset", int'(scl_drive_low), 0);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 done after reset", int'(done), 0);

    // R2: reset default of 44 with a zero frequency input
    do_start(44, 1'b0, "R2 default");
    do_stop(44, 0, "R2 default");

    // R2: formula sweep over clamp and rounding edges
    foreach (freqs[i]) begin
      sys_freq_hz = 32'(freqs[i]);
      repeat (60) @(negedge clk);
      d = exp_dly(freqs[i]);
      do_start(d, 1'b0, "R2 sweep");
      do_stop(d, 0, "R2 sweep");
    end
    sys_freq_hz = 32'd0;
    repeat (60) @(negedge clk);
    do_start(118, 1'b0, "R2 zero keeps");
    do_stop(118, 0, "R2 zero keeps");

    sys_freq_hz = 32'd24000000;
    repeat (60) @(negedge clk);
    d = 3;
    do_start(d, 1'b0, "R3 idle");

    // R5: every byte written, slave ack alternating
    s0 = start_cnt; p0 = stop_cnt;
    for (int b = 0; b < 256; b++) do_write(d, 8'(b), logic'(b[0]), 0, 1'b0);
    chk("R5 no start/stop inside writes", (start_cnt - s0) + (stop_cnt - p0), 0);

    // R3: repeated start with SCL low
    do_start(d, 1'b1, "R3 repeated");

    // R6: every byte read, master ack alternating
    s0 = start_cnt; p0 = stop_cnt;
    for (int b = 0; b < 256; b++) do_read(d, 8'(b), logic'(b[1]));
    chk("R6 no start/stop inside reads", (start_cnt - s0) + (stop_cnt - p0), 0);

    // R7: clock stretching by a slave
    stretch_len = 5; stretch_en = 1'b1;
    do_write(d, 8'hA5, 1'b0, 9*5, 1'b0);
    do_stop(d, 5, "R7 stretched");
    stretch_en = 1'b0; stretch_len = 0;

    // R8: command injected while busy is ignored
    do_start(d, 1'b0, "R8 setup");
    do_write(d, 8'h3C, 1'b0, 0, 1'b1);
    dc = done_cnt;
    repeat (60) @(negedge clk);
    chk("R8 no extra done after ignored command", done_cnt - dc, 0);
    chk("R8 idle after ignored command", int'(busy), 0);
    do_stop(d, 0, "R8 close");

    $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
    $finish;
  end
endmodule